// File: doc/BRIEF.md
# Bus Master Ownership Slice Timer

This block times how long a bus initiator may keep ownership of the bus once it has started a transaction. Software programs a slice length into an 8-bit configuration register. Each time the initiator begins a transaction, a down-counter loads the slice length. The counter then decrements on every clock in which the initiator owns the bus.

When the count reaches zero, the slice has expired. If the arbiter has also removed the grant by then, the block asks the initiator to end its burst. The bus interface logic uses that request to close the current transfer at the next suitable data phase.

The register holds only the upper five bits, so slice lengths come in steps of 8 clocks. A programmed value of zero is treated as the longest slice, 256 clocks. Arbitration and bus signalling are handled elsewhere.

Top module: `mstr_slice_timer`

## Requirements
- R1: `cfg_rdata` always shows the slice register, and a write on `cfg_wr` is visible on `cfg_rdata` from the clock after the write edge.
- R2: Bits 7 to 3 of the register take whatever value is written on `cfg_wdata[7:3]`.
- R3: Bits 2 to 0 of `cfg_rdata` read 0 whatever is written on `cfg_wdata[2:0]`.
- R4: After reset the register reads 0x00, and `slice_expired` and `release_req` are low.
- R5: A register value of 0x00 gives a slice of 256 owned clocks.
- R6: A `txn_start` pulse loads the counter with the slice length and clears `slice_expired` at that edge. It takes priority over counting in the same cycle.
- R7: The counter decrements only on edges where `bus_own` is high; on other edges the count and `slice_expired` hold.
- R8: `slice_expired` rises on the Nth owned edge after a load with slice N. It then stays high until the next `txn_start`.
- R9: `release_req` is high exactly when `slice_expired` is high and `gnt` (1 = granted) is low, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe for the slice register |
| cfg_wdata | input | 8 | Configuration write data |
| txn_start | input | 1 | One-cycle pulse when the initiator starts a transaction |
| bus_own | input | 1 | High while the initiator owns the bus |
| gnt | input | 1 | Arbiter grant, 1 = granted |
| cfg_rdata | output | 8 | Slice register readback |
| slice_expired | output | 1 | Slice count has reached zero since the last load |
| release_req | output | 1 | Initiator must end its burst |

## Verification
The bench programs a value of zero and counts 256 owned clocks. A design that treated zero as zero time would expire at once, and one that used an 8-bit counter would never expire. The bench writes values with low bits set, which catches a register that stores the hardwired bits.

Ownership gaps and mid-slice `txn_start` pulses expose counters that run while not owning the bus, or that keep a stale expiry across a reload. Toggling `gnt` around expiry catches a release request that ignores the grant or that lags by a cycle.

// File: rtl/slice_pkg.sv
package slice_pkg;
   localparam int SLICE_REG_W      = 8;
   localparam int SLICE_FIXED_LSBS = 3;
   localparam bit SLICE_ZERO_MAX   = 1'b1;
endpackage

// File: rtl/slice_cfg_reg.sv
module slice_cfg_reg #(
   parameter int REG_W      = 8,
   parameter int FIXED_LSBS = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] value
);
   localparam logic [REG_W-1:0] WR_MASK = ~((REG_W)'((1 << FIXED_LSBS) - 1));

   if (FIXED_LSBS >= REG_W) begin : g_bad_lsbs
      $error("slice_cfg_reg: FIXED_LSBS must be below REG_W");
   end

   logic [REG_W-1:0] val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= '0;
      else if (wr) val_q <= wdata & WR_MASK;
   end

   assign value = val_q;
endmodule

// File: rtl/slice_down_cnt.sv
module slice_down_cnt #(
   parameter int REG_W     = 8,
   parameter bit ZERO_MAX  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             own,
   input  logic [REG_W-1:0] slice,
   output logic             expired
);
   localparam int CNT_W = REG_W + 1;

   logic [CNT_W-1:0] load_val;
   logic             load_zero;
   logic [CNT_W-1:0] cnt_q;
   logic             exp_q;

   if (ZERO_MAX) begin : g_zero_max
      assign load_val  = (slice == '0) ? (CNT_W)'(1 << REG_W) : {1'b0, slice};
      assign load_zero = 1'b0;
   end else begin : g_zero_raw
      assign load_val  = {1'b0, slice};
      assign load_zero = (slice == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else if (load) begin
         cnt_q <= load_val;
         exp_q <= load_zero;
      end else if (own && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == (CNT_W)'(1)) exp_q <= 1'b1;
      end
   end

   assign expired = exp_q;
endmodule

// File: rtl/mstr_slice_timer.sv
module mstr_slice_timer
   import slice_pkg::*;
#(
   parameter int REG_W      = SLICE_REG_W,
   parameter int FIXED_LSBS = SLICE_FIXED_LSBS,
   parameter bit ZERO_MAX   = SLICE_ZERO_MAX
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic             txn_start,
   input  logic             bus_own,
   input  logic             gnt,
   output logic [REG_W-1:0] cfg_rdata,
   output logic             slice_expired,
   output logic             release_req
);
   if (REG_W < 2 || REG_W > 16) begin : g_bad_width
      $error("mstr_slice_timer: REG_W out of range");
   end

   logic [REG_W-1:0] slice_val;

   slice_cfg_reg #(.REG_W(REG_W), .FIXED_LSBS(FIXED_LSBS)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .wdata (cfg_wdata),
      .value (slice_val)
   );

   slice_down_cnt #(.REG_W(REG_W), .ZERO_MAX(ZERO_MAX)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (txn_start),
      .own     (bus_own),
      .slice   (slice_val),
      .expired (slice_expired)
   );

   assign cfg_rdata   = slice_val;
   assign release_req = slice_expired & ~gnt;
endmodule

// File: rtl/mstr_slice_timer_chk.sv
module mstr_slice_timer_chk #(
   parameter int REG_W      = 8,
   parameter int FIXED_LSBS = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr,
   input logic [REG_W-1:0] cfg_wdata,
   input logic             txn_start,
   input logic             bus_own,
   input logic             gnt,
   input logic [REG_W-1:0] cfg_rdata,
   input logic             slice_expired,
   input logic             release_req
);
   localparam logic [REG_W-1:0] LOW_MASK = (REG_W)'((1 << FIXED_LSBS) - 1);

   AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & LOW_MASK) == '0); // R3
   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> cfg_rdata == ($past(cfg_wdata) & ~LOW_MASK)); // R2
   AST_REG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> $stable(cfg_rdata)); // R1
   AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      txn_start |=> !slice_expired); // R6
   AST_EXPIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (slice_expired && !txn_start) |=> slice_expired); // R8
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!txn_start && !bus_own) |=> $stable(slice_expired)); // R7
   AST_RELEASE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
      release_req == (slice_expired && !gnt)); // R9
endmodule

bind mstr_slice_timer mstr_slice_timer_chk #(.REG_W(REG_W), .FIXED_LSBS(FIXED_LSBS)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_wr        (cfg_wr),
   .cfg_wdata     (cfg_wdata),
   .txn_start     (txn_start),
   .bus_own       (bus_own),
   .gnt           (gnt),
   .cfg_rdata     (cfg_rdata),
   .slice_expired (slice_expired),
   .release_req   (release_req)
);

// File: tb/sim_mstr_slice_timer.sv
module sim_mstr_slice_timer;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic       txn_start = 1'b0;
   logic       bus_own = 1'b0;
   logic       gnt = 1'b1;
   logic [7:0] cfg_rdata;
   logic       slice_expired;
   logic       release_req;

   int checks = 0;
   int errors = 0;
   int m_reg = 0;
   int m_cnt = 0;
   bit m_exp = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mstr_slice_timer u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .txn_start(txn_start), .bus_own(bus_own), .gnt(gnt),
      .cfg_rdata(cfg_rdata), .slice_expired(slice_expired), .release_req(release_req)
   );

   function automatic int slice_len(int r);
      return (r == 0) ? 256 : r;
   endfunction

   function automatic int masked(int d);
      return d & 8'hF8;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      chk({"R1 rdata ", tag}, cfg_rdata, m_reg);
      chk({"R8 expired ", tag}, slice_expired, m_exp);
      chk({"R9 release ", tag}, release_req, m_exp && !gnt);
   endtask

   // Drives inputs at the negedge, updates the model at the posedge and
   // samples a quarter period later.
   task automatic step(bit wr, int wd, bit st, bit own, bit g, string tag);
      cfg_wr = wr; cfg_wdata = 8'(wd); txn_start = st; bus_own = own; gnt = g;
      @(posedge clk);
      if (st) begin
         m_cnt = slice_len(m_reg);
         m_exp = 1'b0;
      end else if (own && m_cnt != 0) begin
         m_cnt--;
         if (m_cnt == 0) m_exp = 1'b1;
      end
      if (wr) m_reg = masked(wd);
      #(CLK_PERIOD/4);
      check_all(tag);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h5A1CE;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      chk("R4 reset rdata", cfg_rdata, 0);
      chk("R4 reset expired", slice_expired, 0);
      chk("R4 reset release", release_req, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3: write with low bits set
      step(1, 8'hFF, 0, 0, 1, "R2 R3 write ff");
      chk("R3 low bits", cfg_rdata & 7, 0);
      step(1, 8'h0F, 0, 0, 1, "R3 write 0f");
      chk("R2 value 08", cfg_rdata, 8'h08);

      // R8: slice 8 expires on 8th owned edge
      step(0, 0, 1, 0, 1, "R6 load");
      for (int i = 0; i < 7; i++) step(0, 0, 0, 1, 1, "R8 counting");
      chk("R8 not yet", slice_expired, 0);
      // R7: idle cycles hold
      for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, "R7 idle hold");
      chk("R7 held", slice_expired, 0);
      step(0, 0, 0, 1, 1, "R8 expiry edge");
      chk("R8 expired", slice_expired, 1);
      chk("R9 granted no release", release_req, 0);
      step(0, 0, 0, 1, 0, "R9 grant removed");
      chk("R9 release", release_req, 1);
      // R6: reload clears even with own
      step(0, 0, 1, 1, 0, "R6 reload");
      chk("R6 cleared", slice_expired, 0);
      chk("R9 no release after reload", release_req, 0);

      // R5: zero means 256
      step(1, 8'h07, 0, 0, 1, "R5 write zero");
      step(0, 0, 1, 0, 1, "R5 load");
      for (int i = 0; i < 255; i++) step(0, 0, 0, 1, 1, "R5 counting");
      chk("R5 not before 256", slice_expired, 0);
      step(0, 0, 0, 1, 0, "R5 256th");
      chk("R5 expired at 256", slice_expired, 1);

      // Random phase
      for (int i = 0; i < 4000; i++) begin
         bit wr, st, own, g;
         int wd;
         wr  = ($urandom % 24) == 0;
         wd  = $urandom % 256;
         st  = ($urandom % 20) == 0;
         own = ($urandom % 4) != 0;
         g   = ($urandom % 2) == 0;
         step(wr, wd, st, own, g, "random");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule